// File: doc/BRIEF.md
# Low-Power Stop Mode Sequencer

This block sequences a small microcontroller into and out of its two standby modes. The CPU sends a one-cycle strobe when it decodes a STOP instruction. The sequencer then looks at a stop-permission bit and a two-bit mode selector taken from the system option registers. It either refuses the request, raises a reset for an illegal instruction, or moves into a standby mode. Its clock comes from the always-running 1 kHz oscillator domain, so it keeps stepping while everything else is halted.

The light standby mode stops every gated clock but keeps all domains powered, so register contents survive. An interrupt restores the clocks and sends a resume indication to the CPU. The deep standby mode also removes power from every regulator-fed domain, puts the regulator into standby and forces the low-voltage detector on. It is left only on an interrupt, or on reset. Once an interrupt has arrived, the wake is still held back until a supply comparator reports that the supply has climbed above the detector re-arm level. The wake is then issued as a power-on-style restart, so the CPU fetches its reset vector.

Top module: `lpstop_ctrl`

## Requirements
- R1: While reset is held and after it is released, `mode` is 2'b00 (running), every bit of `clk_en` and `pwr_en` is high, and `cpu_hold`, `reg_standby`, `lvd_force`, `ill_rst_req`, `por_wake_req` and `resume_req` are low.
- R2: A strobe while `stop_en` is 0 leaves `mode` at 2'b00. It raises `ill_rst_req` for exactly one cycle, starting the cycle after the strobe is sampled.
- R3: With `stop_en` at 1, a strobe picks the deep mode when `stop_sel` is 2'b01, and the light mode for any other selector value. The `mode` codes are: 2'b00 running, 2'b01 deep, 2'b10 light, 2'b11 deep with a wake latched while waiting for supply re-arm. The new mode shows the cycle after the strobe.
- R4: In every nonzero `mode`, all bits of `clk_en` are low, `lfo_clk_en` stays high and `cpu_hold` is high.
- R5: In modes 2'b01 and 2'b11, all bits of `pwr_en` are low and `reg_standby` and `lvd_force` are high. In mode 2'b10, `pwr_en` stays all high and `lvd_force` is low.
- R6: A deep-mode strobe while any bit of `irq_pend` is set is refused. `mode` stays 2'b00, `cpu_hold` stays low and no request output is raised.
- R7: In the deep mode, with no bit of `irq_pend` set, the sequencer stays in mode 2'b01. This holds whatever the values of `supply_ok` and `stop_strobe`.
- R8: An interrupt in the deep mode while `supply_ok` is 0 moves to mode 2'b11. The block then stays there, even if the interrupt clears, until `supply_ok` is 1.
- R9: Leaving the deep mode (from 2'b01 with an interrupt and `supply_ok`, or from 2'b11 with `supply_ok`) returns `mode` to 2'b00. It gives a one-cycle `por_wake_req` and no `resume_req`.
- R10: An interrupt in the light mode returns `mode` to 2'b00 with a one-cycle `resume_req` and no `por_wake_req`.
- R11: Driving `rst_n` low returns the block to the R1 state at once, with no clock edge, from any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_strobe | input | 1 | One-cycle strobe for a decoded STOP instruction |
| stop_en | input | 1 | Stop-permission bit |
| stop_sel | input | 2 | Stop mode selector (2'b01 = deep) |
| irq_pend | input | N_IRQ | Pending interrupt flags |
| supply_ok | input | 1 | Supply is above the detector re-arm level |
| clk_en | output | N_CLK | Gated clock enables |
| lfo_clk_en | output | 1 | Low-frequency oscillator enable, always high |
| pwr_en | output | N_DOM | Regulator-fed domain power enables |
| reg_standby | output | 1 | Puts the regulator into low-power standby |
| lvd_force | output | 1 | Forces the low-voltage detector on |
| cpu_hold | output | 1 | Holds the CPU while stopped |
| ill_rst_req | output | 1 | Illegal-opcode reset request pulse |
| por_wake_req | output | 1 | Power-on-style wake request pulse |
| resume_req | output | 1 | Resume pulse after light-mode wake |
| mode | output | 2 | Current mode code |

## Verification
The mode register and the three request pulses all change on the same edge that samples a strobe, interrupt or supply change. The enables are decoded directly from the mode register, so every result is due one edge after the stimulus. The bench drives inputs on the falling edge, waits one rising edge and samples 1 ns later, before the next vector is applied. This means a one-cycle pulse is seen exactly once, and a result that comes a cycle late fails. The asynchronous reset check samples without any clock edge, and the reset-release check waits out the two-stage synchronizer.

// File: rtl/lpstop_pkg.sv
package lpstop_pkg;
  typedef enum logic [1:0] {
    M_RUN   = 2'b00,
    M_DEEP  = 2'b01,
    M_LIGHT = 2'b10,
    M_REARM = 2'b11
  } lp_mode_e;

  localparam int unsigned SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_DEEP = 2'b01;
endpackage

// File: rtl/lpstop_rst_sync.sv
module lpstop_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lpstop_fsm.sv
module lpstop_fsm
  import lpstop_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_strobe,
  input  logic             stop_en,
  input  logic [SEL_W-1:0] stop_sel,
  input  logic             irq_any,
  input  logic             supply_ok,
  output lp_mode_e         mode,
  output logic             ill_rst_req,
  output logic             por_wake_req,
  output logic             resume_req
);
  lp_mode_e st_q, st_d;
  logic     ill_d, por_d, res_d;

  always_comb begin
    st_d  = st_q;
    ill_d = 1'b0;
    por_d = 1'b0;
    res_d = 1'b0;
    unique case (st_q)
      M_RUN: begin
        if (stop_strobe) begin
          if (!stop_en)                  ill_d = 1'b1;
          else if (stop_sel != SEL_DEEP) st_d  = M_LIGHT;
          else if (!irq_any)             st_d  = M_DEEP;
        end
      end
      M_LIGHT: begin
        if (irq_any) begin
          st_d  = M_RUN;
          res_d = 1'b1;
        end
      end
      M_DEEP: begin
        if (irq_any) begin
          if (supply_ok) begin
            st_d  = M_RUN;
            por_d = 1'b1;
          end else begin
            st_d = M_REARM;
          end
        end
      end
      M_REARM: begin
        if (supply_ok) begin
          st_d  = M_RUN;
          por_d = 1'b1;
        end
      end
      default: st_d = M_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= M_RUN;
      ill_rst_req  <= 1'b0;
      por_wake_req <= 1'b0;
      resume_req   <= 1'b0;
    end else begin
      st_q         <= st_d;
      ill_rst_req  <= ill_d;
      por_wake_req <= por_d;
      resume_req   <= res_d;
    end
  end

  assign mode = st_q;

  a_r2_illegal_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == M_RUN && stop_strobe && !stop_en) |=> (ill_rst_req && st_q == M_RUN));

  a_r6_deep_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == M_RUN && stop_strobe && stop_en && stop_sel == SEL_DEEP && irq_any)
      |=> (st_q == M_RUN && !ill_rst_req));

  a_r7_deep_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == M_DEEP && !irq_any) |=> (st_q == M_DEEP));

  a_r8_rearm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == M_REARM && !supply_ok) |=> (st_q == M_REARM && !por_wake_req));

  a_r9_deep_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == M_DEEP && irq_any && supply_ok) |=> (st_q == M_RUN && por_wake_req && !resume_req));

  a_r10_light_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == M_LIGHT && irq_any) |=> (st_q == M_RUN && resume_req && !por_wake_req));

  a_r9_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ill_rst_req, por_wake_req, resume_req}));
endmodule

// File: rtl/lpstop_outdec.sv
module lpstop_outdec
  import lpstop_pkg::*;
#(
  parameter int unsigned N_CLK = 4,
  parameter int unsigned N_DOM = 3
) (
  input  lp_mode_e         mode,
  output logic [N_CLK-1:0] clk_en,
  output logic             lfo_clk_en,
  output logic [N_DOM-1:0] pwr_en,
  output logic             reg_standby,
  output logic             lvd_force,
  output logic             cpu_hold
);
  logic stopped, deep;

  assign stopped = (mode != M_RUN);
  assign deep    = (mode == M_DEEP) || (mode == M_REARM);

  for (genvar c = 0; c < N_CLK; c++) begin : g_clk
    assign clk_en[c] = !stopped;
  end

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    assign pwr_en[d] = !deep;
  end

  assign lfo_clk_en  = 1'b1;
  assign reg_standby = deep;
  assign lvd_force   = deep;
  assign cpu_hold    = stopped;
endmodule

// File: rtl/lpstop_ctrl.sv
module lpstop_ctrl
  import lpstop_pkg::*;
#(
  parameter int unsigned N_CLK       = 4,
  parameter int unsigned N_DOM       = 3,
  parameter int unsigned N_IRQ       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_strobe,
  input  logic             stop_en,
  input  logic [SEL_W-1:0] stop_sel,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic             supply_ok,
  output logic [N_CLK-1:0] clk_en,
  output logic             lfo_clk_en,
  output logic [N_DOM-1:0] pwr_en,
  output logic             reg_standby,
  output logic             lvd_force,
  output logic             cpu_hold,
  output logic             ill_rst_req,
  output logic             por_wake_req,
  output logic             resume_req,
  output logic [1:0]       mode
);
  logic     rst_sync_n;
  logic     irq_any;
  lp_mode_e mode_w;

  assign irq_any = |irq_pend;

  lpstop_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lpstop_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .stop_strobe  (stop_strobe),
    .stop_en      (stop_en),
    .stop_sel     (stop_sel),
    .irq_any      (irq_any),
    .supply_ok    (supply_ok),
    .mode         (mode_w),
    .ill_rst_req  (ill_rst_req),
    .por_wake_req (por_wake_req),
    .resume_req   (resume_req)
  );

  lpstop_outdec #(.N_CLK(N_CLK), .N_DOM(N_DOM)) u_outdec (
    .mode        (mode_w),
    .clk_en      (clk_en),
    .lfo_clk_en  (lfo_clk_en),
    .pwr_en      (pwr_en),
    .reg_standby (reg_standby),
    .lvd_force   (lvd_force),
    .cpu_hold    (cpu_hold)
  );

  assign mode = mode_w;

  a_r4_clocks_gated: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode != 2'b00) |-> (clk_en == '0 && lfo_clk_en && cpu_hold));

  a_r5_deep_lvd: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == 2'b01 || mode == 2'b11) |-> (pwr_en == '0 && lvd_force && reg_standby));
endmodule

// File: tb/lpstop_ctrl_tb.sv
module lpstop_ctrl_tb;
  localparam int N_CLK = 4;
  localparam int N_DOM = 3;
  localparam int N_IRQ = 8;
  localparam int NV    = 21;

  logic             clk;
  logic             rst_n;
  logic             stop_strobe, stop_en, supply_ok;
  logic [1:0]       stop_sel;
  logic [N_IRQ-1:0] irq_pend;
  logic [N_CLK-1:0] clk_en;
  logic [N_DOM-1:0] pwr_en;
  logic             lfo_clk_en, reg_standby, lvd_force, cpu_hold;
  logic             ill_rst_req, por_wake_req, resume_req;
  logic [1:0]       mode;

  int errors = 0;
  int checks = 0;

  lpstop_ctrl #(.N_CLK(N_CLK), .N_DOM(N_DOM), .N_IRQ(N_IRQ)) u_dut (
    .clk(clk), .rst_n(rst_n), .stop_strobe(stop_strobe), .stop_en(stop_en),
    .stop_sel(stop_sel), .irq_pend(irq_pend), .supply_ok(supply_ok),
    .clk_en(clk_en), .lfo_clk_en(lfo_clk_en), .pwr_en(pwr_en),
    .reg_standby(reg_standby), .lvd_force(lvd_force), .cpu_hold(cpu_hold),
    .ill_rst_req(ill_rst_req), .por_wake_req(por_wake_req),
    .resume_req(resume_req), .mode(mode)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // vector: strobe en sel[1:0] irq sup | mode[1:0] ill por res
  localparam logic [10:0] VEC [NV] = '{
    11'b0_0_00_0_0_00_000, // R1 idle
    11'b1_0_00_0_0_00_100, // R2 illegal stop
    11'b0_0_00_0_0_00_000, // R2 pulse ends
    11'b1_1_01_1_0_00_000, // R6 refused
    11'b1_1_01_0_0_01_000, // R3 deep entry
    11'b0_0_00_0_1_01_000, // R7 supply alone
    11'b1_1_10_0_1_01_000, // R7 strobe ignored
    11'b0_0_00_1_1_00_010, // R9 deep wake
    11'b0_0_00_0_1_00_000, // R9 pulse ends
    11'b1_1_10_0_1_10_000, // R3 light sel 10
    11'b0_0_00_0_1_10_000, // R10 stays
    11'b0_0_00_1_1_00_001, // R10 resume
    11'b1_1_00_0_1_10_000, // R3 light sel 00
    11'b0_0_00_1_0_00_001, // R10 resume
    11'b1_1_11_0_0_10_000, // R3 light sel 11
    11'b0_0_00_1_0_00_001, // R10 resume
    11'b1_1_01_0_0_01_000, // R3 deep again
    11'b0_0_00_1_0_11_000, // R8 wait re-arm
    11'b0_0_00_0_0_11_000, // R8 held
    11'b0_0_00_0_1_00_010, // R8 R9 re-arm wake
    11'b0_0_00_0_0_00_000  // idle
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_outputs(input logic [1:0] m, input int idx);
    bit deep;
    deep = (m == 2'b01) || (m == 2'b11);
    chk(mode == m, $sformatf("R3 mode vec %0d", idx), 32'(mode), 32'(m));
    chk(clk_en == ((m == 2'b00) ? '1 : '0) && lfo_clk_en && cpu_hold == (m != 2'b00),
        $sformatf("R4 clocks vec %0d", idx), {clk_en, lfo_clk_en, cpu_hold},
        {((m == 2'b00) ? 4'hF : 4'h0), 1'b1, 1'(m != 2'b00)});
    chk(pwr_en == (deep ? '0 : '1) && lvd_force == deep && reg_standby == deep,
        $sformatf("R5 power vec %0d", idx), {pwr_en, lvd_force, reg_standby},
        {(deep ? 3'b000 : 3'b111), deep, deep});
  endtask

  initial begin
    #150000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    stop_strobe = 1'b0; stop_en = 1'b0; stop_sel = 2'b00;
    irq_pend = '0; supply_ok = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    chk(mode == 2'b00 && !ill_rst_req && !por_wake_req && !resume_req,
        "R1 reset state", {mode, ill_rst_req, por_wake_req, resume_req}, 0);
    chk_outputs(2'b00, -1);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(mode == 2'b00 && !cpu_hold, "R1 after release", {mode, cpu_hold}, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      stop_strobe = VEC[i][10];
      stop_en     = VEC[i][9];
      stop_sel    = VEC[i][8:7];
      irq_pend    = VEC[i][6] ? 8'h10 : 8'h00;
      supply_ok   = VEC[i][5];
      @(posedge clk); #1;
      chk_outputs(VEC[i][4:3], i);
      chk({ill_rst_req, por_wake_req, resume_req} == VEC[i][2:0],
          $sformatf("R2 R9 R10 requests vec %0d", i),
          {ill_rst_req, por_wake_req, resume_req}, VEC[i][2:0]);
    end

    // R6 refused entry with a different interrupt bit
    @(negedge clk);
    stop_strobe = 1'b1; stop_en = 1'b1; stop_sel = 2'b01; irq_pend = 8'h80;
    @(posedge clk); #1;
    chk(mode == 2'b00 && !cpu_hold && !ill_rst_req, "R6 refused msb irq",
        {mode, cpu_hold, ill_rst_req}, 0);

    // R11 asynchronous reset from deep mode
    @(negedge clk);
    stop_strobe = 1'b1; stop_en = 1'b1; stop_sel = 2'b01; irq_pend = '0; supply_ok = 1'b0;
    @(posedge clk); #1;
    stop_strobe = 1'b0;
    chk(mode == 2'b01, "R11 deep before reset", 32'(mode), 1);
    #1 rst_n = 1'b0;
    #1;
    chk(mode == 2'b00 && clk_en == '1 && pwr_en == '1 && !lvd_force,
        "R11 async reset", {mode, clk_en, pwr_en, lvd_force}, {2'b00, 4'hF, 3'h7, 1'b0});
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule